// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Generation

The block is the transmit half of an asynchronous serial port. Software-side logic pushes 8-bit characters into a four-entry holding queue. A framing state machine pulls them one at a time into a shift register and sends each as one low start bit, eight data bits least significant bit first, and one high stop bit. An external baud-tick strobe sets the pace, and every bit lasts sixteen ticks. The line rests high between frames.

A break request makes the next frame a synchronisation break instead of a character. It is a start bit, twelve low bit times and a stop bit, so the line stays low for thirteen bit times. The request flag clears itself when that frame finishes. An interrupt pulse can be tied to one of three points in the flow: each hand-off from the queue to the shift register, the hand-off that empties the queue, or the completion of all pending work. Dropping the enable aborts everything and returns the pad to the general-purpose port.

The framing state machine has five states. IDLE keeps the line high. START drives the start bit. DATA shifts out the eight data bits. ZERO drives the twelve low break bits. STOP drives the stop bit. The transitions are as follows. IDLE goes to START when a break is pending (this has priority), or when the queue holds a character, which is then popped. START goes to ZERO for a break frame and to DATA otherwise. DATA goes to STOP after its eighth bit. ZERO goes to STOP after its twelfth bit. STOP goes back to IDLE. Any state goes to IDLE when the enable is low.

Top module: `serial_tx_engine`

## Requirements
- R1: While enabled, each character is framed as a low start bit, data bits 0 through 7 in that order, and a high stop bit. Each bit holds for 16 baud ticks, and the line is high when no frame is active.
- R2: The queue holds up to 4 characters. `buf_full` is 1 exactly when 4 are held. A write while full, or while disabled, is dropped and leaves the queue contents unchanged.
- R3: `tx_idle` is 1 only when no frame is being sent and the queue is empty.
- R4: With `irq_mode` = 2'b00, `irq` pulses once for every character moved from the queue into the shift register.
- R5: With `irq_mode` = 2'b10, `irq` pulses only for a move that leaves the queue empty, judged on the queue occupancy before that cycle's write.
- R6: With `irq_mode` = 2'b01, `irq` pulses when a stop bit ends while the queue is empty and no further break is pending.
- R7: With `irq_mode` = 2'b11, `irq` never pulses.
- R8: `irq` is a one-cycle pulse, registered one clock after the cycle in which its condition holds.
- R9: A `brk_set` pulse while enabled raises `brk_busy`. The next frame to start is a break: the line goes low for 13 bit times (start plus 12 zero bits), then high for the stop bit. It takes priority over queued characters, and `brk_busy` clears at the end of its stop bit.
- R10: While `tx_en` is low, from the following clock on, any frame is aborted, the queue is emptied, a pending break is dropped, `txd` is high and `txd_oe` is 0. Writes and `brk_set` have no effect.
- R11: After reset, `txd`=1, `txd_oe`=0, `buf_full`=0, `tx_idle`=1, `brk_busy`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; low aborts and flushes |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to queue |
| irq_mode | input | 2 | Interrupt condition select |
| brk_set | input | 1 | Request a break as the next frame |
| baud_tick | input | 1 | Bit-rate strobe, 16 per bit |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Pad ownership: 1 when the transmitter drives the pin |
| buf_full | output | 1 | Queue cannot accept a character |
| tx_idle | output | 1 | Shift register and queue both empty |
| brk_busy | output | 1 | Break requested and not yet completed |
| irq | output | 1 | Interrupt pulse |

## Verification
On every cycle the assertions check that the disable path clears the pad ownership, the break flag and the busy status. They also check that the reserved mode stays silent, that the interrupt never lasts two cycles, that the break flag falls only at a break's stop bit or on disable, that a full queue keeps its count when a write is refused, and that every data frame carries exactly eight bits. Only the bench's scenarios can show the exact position of each bit edge against the tick count, which character arrives in which frame after overflow, and how break priority orders a break against queued data. The same holds for the moment at which each interrupt mode fires.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ZERO,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/txq_buffer.sv
module txq_buffer #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: a refused write leaves the occupancy at its ceiling
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R2: the framer never pops an empty queue
    p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import serial_tx_pkg::*;
#(
    parameter int W        = 8,
    parameter int TICKS    = 16,
    parameter int BRK_BITS = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         baud_tick,
    input  logic         brk_pend,
    input  logic         have_data,
    input  logic [W-1:0] din,
    output logic         pop,
    output logic         txd,
    output logic         busy,
    output logic         frame_end,
    output logic         frame_brk
);
    localparam int TW       = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int BITS_MAX = (W > BRK_BITS) ? W : BRK_BITS;
    localparam int BW       = $clog2(BITS_MAX + 1);

    tx_state_e     state, st_n;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bcnt;
    logic [W-1:0]  shreg;
    logic          is_brk;
    logic          bit_end;

    assign bit_end = baud_tick && (tcnt == TW'(TICKS - 1));

    always_comb begin
        st_n      = state;
        pop       = 1'b0;
        frame_end = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (brk_pend) begin
                    st_n = ST_START;
                end else if (have_data) begin
                    st_n = ST_START;
                    pop  = 1'b1;
                end
            end
            ST_START: if (bit_end) st_n = is_brk ? ST_ZERO : ST_DATA;
            ST_DATA:  if (bit_end && bcnt == BW'(W - 1)) st_n = ST_STOP;
            ST_ZERO:  if (bit_end && bcnt == BW'(BRK_BITS - 1)) st_n = ST_STOP;
            ST_STOP: begin
                if (bit_end) begin
                    st_n      = ST_IDLE;
                    frame_end = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (!en) begin
            st_n      = ST_IDLE;
            pop       = 1'b0;
            frame_end = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            is_brk <= 1'b0;
        end else begin
            state <= st_n;
            if (state == ST_IDLE) begin
                tcnt <= '0;
                bcnt <= '0;
                if (pop) begin
                    shreg  <= din;
                    is_brk <= 1'b0;
                end else if (st_n == ST_START) begin
                    is_brk <= 1'b1;
                end
            end else if (baud_tick) begin
                if (bit_end) begin
                    tcnt <= '0;
                    if (state == ST_DATA || state == ST_ZERO) bcnt <= bcnt + 1'b1;
                    if (state == ST_DATA) shreg <= shreg >> 1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_START, ST_ZERO: txd = 1'b0;
            ST_DATA:           txd = shreg[0];
            default:           txd = 1'b1;
        endcase
        busy      = (state != ST_IDLE);
        frame_brk = is_brk;
    end

    // R10: disable forces the framer home on the next clock
    p_abort_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));

    // R1: a data frame reaches its stop bit only after eight data bits
    p_eight_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && $past(state) == ST_DATA) |-> (bcnt == BW'(W)));

    // R1: a frame is only ever entered from rest
    p_start_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
    parameter int DATA_W        = 8,
    parameter int DEPTH         = 4,
    parameter int TICKS_PER_BIT = 16,
    parameter int BREAK_BITS    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        irq_mode,
    input  logic              brk_set,
    input  logic              baud_tick,
    output logic              txd,
    output logic              txd_oe,
    output logic              buf_full,
    output logic              tx_idle,
    output logic              brk_busy,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] q_dout;
    logic [CW-1:0]     q_count;
    logic              q_full, q_empty;
    logic              pop, busy, frame_end, frame_brk;
    logic              irq_cond;
    logic              fsm_txd;

    txq_buffer #(.W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!tx_en),
        .push  (wr_stb && tx_en),
        .din   (wr_data),
        .pop   (pop),
        .dout  (q_dout),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    tx_frame_fsm #(.W(DATA_W), .TICKS(TICKS_PER_BIT), .BRK_BITS(BREAK_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .baud_tick (baud_tick),
        .brk_pend  (brk_busy),
        .have_data (!q_empty),
        .din       (q_dout),
        .pop       (pop),
        .txd       (fsm_txd),
        .busy      (busy),
        .frame_end (frame_end),
        .frame_brk (frame_brk)
    );

    always_comb begin
        unique case (irq_mode)
            2'b00:   irq_cond = pop;
            2'b10:   irq_cond = pop && (q_count == CW'(1));
            2'b01:   irq_cond = frame_end && q_empty && (frame_brk || !brk_busy);
            default: irq_cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_busy <= 1'b0;
            txd_oe   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            txd_oe <= tx_en;
            irq    <= tx_en && irq_cond;
            if (!tx_en)                       brk_busy <= 1'b0;
            else if (brk_set)                 brk_busy <= 1'b1;
            else if (frame_end && frame_brk)  brk_busy <= 1'b0;
        end
    end

    assign txd      = fsm_txd;
    assign buf_full = q_full;
    assign tx_idle  = !busy && q_empty;

    // R10: disable releases the pad and clears everything by the next clock
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!txd_oe && txd && tx_idle && !brk_busy));

    // R7: the reserved mode never produces an interrupt
    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b11) |=> !irq);

    // R8: the interrupt is never wider than one cycle
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: the break flag falls only at the end of a break frame or on disable
    p_break_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_busy) |-> (!$past(tx_en) || $past(frame_end && frame_brk)));

    // R3: a full queue can never read as idle
    p_full_not_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !tx_idle);
endmodule

// File: tb/serial_tx_engine_test.sv
module serial_tx_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int M_IDLE = 0, M_START = 1, M_DATA = 2, M_ZERO = 3, M_STOP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] irq_mode = 2'b00;
    logic       brk_set = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, txd_oe, buf_full, tx_idle, brk_busy, irq;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;

    // reference model state
    logic [7:0] q[$];
    int         m_st = M_IDLE;
    int         m_tc = 0;
    int         m_bc = 0;
    logic [7:0] m_sh = '0;
    bit         m_isbrk = 1'b0;
    bit         m_brk = 1'b0;
    bit         m_oe = 1'b0;
    bit         m_irq = 1'b0;

    int low_run = 0;
    int max_low = 0;
    int irq_seen = 0;
    int tick_div = 0;

    serial_tx_engine uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .irq_mode(irq_mode), .brk_set(brk_set), .baud_tick(baud_tick),
        .txd(txd), .txd_oe(txd_oe), .buf_full(buf_full), .tx_idle(tx_idle),
        .brk_busy(brk_busy), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tick_div  = (tick_div == 2) ? 0 : tick_div + 1;
        baud_tick = (tick_div == 2);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // behavioural reference, updated at every rising edge from inputs only
    always @(posedge clk) begin
        int c0;
        bit b0;
        bit irqn;
        if (!rst_n) begin
            q.delete();
            m_st = M_IDLE; m_tc = 0; m_bc = 0; m_sh = '0;
            m_isbrk = 0; m_brk = 0; m_oe = 0; m_irq = 0;
        end else if (!tx_en) begin
            q.delete();
            m_st = M_IDLE; m_brk = 0; m_oe = 0; m_irq = 0;
        end else begin
            c0 = q.size();
            b0 = m_brk;
            irqn = 0;
            m_oe = 1;
            if (m_st == M_IDLE) begin
                m_tc = 0;
                m_bc = 0;
                if (b0) begin
                    m_st = M_START;
                    m_isbrk = 1;
                end else if (c0 > 0) begin
                    m_sh = q.pop_front();
                    m_isbrk = 0;
                    m_st = M_START;
                    irqn = (irq_mode == 2'b00) || (irq_mode == 2'b10 && c0 == 1);
                end
            end else if (baud_tick) begin
                if (m_tc == 15) begin
                    m_tc = 0;
                    case (m_st)
                        M_START: m_st = m_isbrk ? M_ZERO : M_DATA;
                        M_DATA: begin
                            m_sh = m_sh >> 1;
                            m_bc++;
                            if (m_bc == 8) m_st = M_STOP;
                        end
                        M_ZERO: begin
                            m_bc++;
                            if (m_bc == 12) m_st = M_STOP;
                        end
                        default: begin
                            m_st = M_IDLE;
                            if (m_isbrk) m_brk = 0;
                            irqn = (irq_mode == 2'b01) && c0 == 0 && (m_isbrk || !b0);
                        end
                    endcase
                end else begin
                    m_tc++;
                end
            end
            if (brk_set) m_brk = 1;
            if (wr_stb && c0 < 4) q.push_back(wr_data);
            m_irq = irqn;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            int exp_txd;
            string itag;
            exp_txd = (m_st == M_START || m_st == M_ZERO) ? 0 :
                      (m_st == M_DATA) ? int'(m_sh[0]) : 1;
            case (irq_mode)
                2'b00:   itag = "R8/R4 irq";
                2'b10:   itag = "R8/R5 irq";
                2'b01:   itag = "R8/R6 irq";
                default: itag = "R8/R7 irq";
            endcase
            chk("R1 txd", int'(txd), exp_txd);
            chk("R10 txd_oe", int'(txd_oe), int'(m_oe));
            chk("R2 buf_full", int'(buf_full), int'(q.size() == 4));
            chk("R3 tx_idle", int'(tx_idle), int'(m_st == M_IDLE && q.size() == 0));
            chk("R9 brk_busy", int'(brk_busy), int'(m_brk));
            chk(itag, int'(irq), int'(m_irq));
            if (irq) irq_seen++;
            if (txd_oe && !txd) low_run++;
            else low_run = 0;
            if (low_run > max_low) max_low = low_run;
        end
    end

    task automatic burst(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_stb  = 1'b1;
            wr_data = base + 8'(i);
        end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic pulse_break();
        @(negedge clk);
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (m_st == M_IDLE && q.size() == 0 && !m_brk) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values
        chk("R11 txd", int'(txd), 1);
        chk("R11 txd_oe", int'(txd_oe), 0);
        chk("R11 buf_full", int'(buf_full), 0);
        chk("R11 tx_idle", int'(tx_idle), 1);
        chk("R11 brk_busy", int'(brk_busy), 0);
        chk("R11 irq", int'(irq), 0);
        cmp_on = 1'b1;

        tx_en = 1'b1;
        repeat (3) @(negedge clk);

        // R4: interrupt on every hand-off
        irq_mode = 2'b00;
        irq_seen = 0;
        burst(3, 8'hA5);
        wait_quiet();
        chk("R4 irq count", irq_seen, 3);

        // R5 / R2: overflow during a frame, interrupt on emptying hand-off
        irq_mode = 2'b10;
        burst(6, 8'h3C);
        chk("R2 full after overflow", int'(buf_full), 1);
        wait_quiet();

        // R6: interrupt only when all work is done
        irq_mode = 2'b01;
        irq_seen = 0;
        burst(2, 8'h81);
        wait_quiet();
        chk("R6 irq count", irq_seen, 1);

        // R7: reserved mode stays silent
        irq_mode = 2'b11;
        irq_seen = 0;
        burst(2, 8'h0F);
        wait_quiet();
        chk("R7 irq count", irq_seen, 0);

        // R9: break requested mid-frame with a character queued behind it
        irq_mode = 2'b01;
        irq_seen = 0;
        max_low = 0;
        burst(1, 8'hFF);
        repeat (20) @(negedge clk);
        fork
            pulse_break();
            burst(1, 8'hFE);
        join
        wait_quiet();
        chk("R9 break low length ok", int'(max_low >= 622 && max_low <= 624), 1);
        chk("R6 irq after break and data", irq_seen, 1);

        // R9: lone break with empty queue
        irq_seen = 0;
        pulse_break();
        wait_quiet();
        chk("R9 lone break irq", irq_seen, 1);

        // R10: abort mid-frame and flush
        irq_mode = 2'b00;
        burst(3, 8'h55);
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R10 oe released", int'(txd_oe), 0);
        chk("R10 flushed", int'(tx_idle), 1);
        pulse_break();
        burst(2, 8'h11);
        chk("R10 break ignored", int'(brk_busy), 0);
        chk("R10 write ignored", int'(tx_idle), 1);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 nothing pending", int'(tx_idle), 1);
        burst(1, 8'h96);
        wait_quiet();

        cmp_on = 1'b0;
        finish_run();
    end
endmodule